// File: doc/BRIEF.md
# Rectangle Blitter with Byte Masks

This block copies a rectangle of pixels from one buffer in graphics memory to another, for example from an off-screen image to the visible frame. The rectangle is described by a source byte address, a destination byte address, a byte stride for each buffer, a line width in bytes and a line count. Software programs these inputs, pulses `start` and waits for `done`.

The memory is reached through one 64-bit port with a byte enable per lane and a request/ready handshake. Source and destination may begin at any byte offset, so the block has three jobs on each line:

- It rounds every access down to an 8-byte word.
- It shifts source bytes into the destination's lane alignment, keeping the previous source word so that every destination word is complete when it is written.
- It masks the partial words at both ends of the line, so that bytes outside the rectangle are never written.

A pixel-size select rounds the addresses and the width to whole 16-bit or 32-bit pixels.

Top module: `rect_blit`

## Requirements
- R1: After reset, `busy`, `done` and `mem_req` are all low.
- R2: A `start` taken while idle, with a non-zero rounded width and height, raises `busy` on the next cycle. `done` pulses for exactly one cycle in the cycle after the last write is accepted, and `busy` is low in that same cycle.
- R3: `mem_addr` always has its three low bits at zero. While `mem_req` is high and `mem_ready` is low, the request, its address and its direction hold steady.
- R4: Bit j of `mem_be` enables data bits 8j+7..8j, which hold the byte at `mem_addr`+j. Destination bytes outside the rectangle keep their old values.
- R5: With any source and destination byte offsets, the destination byte at line offset x equals the source byte at line offset x of the same line.
- R6: Line y starts at the source start plus y times the source stride, and at the destination start plus y times the destination stride. The two strides are independent.
- R7: With `pix32`=1, bits 1:0 of both addresses and of the width are taken as zero (32-bit pixels: 24-bit colour plus 8-bit alpha). With `pix32`=0, bit 0 of each is taken as zero (16-bit pixels).
- R8: If the rounded width or the height is zero, `done` pulses one cycle after `start`, `busy` stays low, and no memory request is made.
- R9: A `start` while `busy` is ignored. Configuration is sampled only when a start is accepted.
- R10: Each line produces exactly one write per destination word it touches, in ascending address order. A line inside a single word is written once, with the AND of its left and right edge masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a copy, taken only when idle |
| pix32 | input | 1 | 1: 32-bit pixels, 0: 16-bit pixels |
| src_addr | input | ADDR_W | Source rectangle first byte address |
| dst_addr | input | ADDR_W | Destination rectangle first byte address |
| src_stride | input | ADDR_W | Bytes between source lines |
| dst_stride | input | ADDR_W | Bytes between destination lines |
| width | input | DIM_W | Line width in bytes |
| height | input | DIM_W | Number of lines |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | 1: write, 0: read |
| mem_addr | output | ADDR_W | Word-aligned byte address |
| mem_be | output | 8 | Byte write enables |
| mem_wdata | output | 64 | Write data |
| mem_rdata | input | 64 | Read data, valid in the accepting cycle |
| mem_ready | input | 1 | Accepts the current request |

## Verification
- **Handshake timing.** Each memory transfer completes at the clock edge where `mem_req` and `mem_ready` are both high. The bench samples both at the falling edge just before that rising edge, and compares every write there against a queue of expected writes built byte by byte from the requirements.
- **Status timing.** `busy`, and for an empty job `done`, are due one cycle after `start`, so they are checked at the first falling edge after the start cycle. After the completion pulse, `done` is checked low one falling edge later.
- **Whole-memory check.** Once `done` is seen, the whole memory image is compared, which covers bytes outside the rectangle.
- **Ready patterns.** `mem_ready` follows several stall patterns, so that the timing of the results is exercised across different waits.

// File: rtl/rect_blit.sv
module rect_blit #(
  parameter int ADDR_W = 32,
  parameter int DIM_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              pix32,
  input  logic [ADDR_W-1:0] src_addr,
  input  logic [ADDR_W-1:0] dst_addr,
  input  logic [ADDR_W-1:0] src_stride,
  input  logic [ADDR_W-1:0] dst_stride,
  input  logic [DIM_W-1:0]  width,
  input  logic [DIM_W-1:0]  height,
  output logic              busy,
  output logic              done,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_be,
  output logic [63:0]       mem_wdata,
  input  logic [63:0]       mem_rdata,
  input  logic              mem_ready
);
  localparam int WC_W = DIM_W + 1;
  localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(7);

  typedef enum logic [2:0] {S_IDLE, S_LINE, S_PRIME, S_RD, S_WR} st_t;
  st_t st;

  logic [ADDR_W-1:0] sline, dline, sstr, dstr, sptr, dptr;
  logic [DIM_W-1:0]  wbytes, lines;
  logic [WC_W-1:0]   wleft;
  logic              first, done_q;
  logic [2:0]        doff, eoff, sh;
  logic [63:0]       cur, prev;

  wire [ADDR_W-1:0] a_round = ~ADDR_W'(pix32 ? 3 : 1);
  wire [DIM_W-1:0]  w_in    = width & ~DIM_W'(pix32 ? 3 : 1);
  wire              empty   = (w_in == '0) || (height == '0);

  wire [WC_W-1:0]   l_last = WC_W'(dline[2:0]) + WC_W'(wbytes) - WC_W'(1);
  wire [WC_W-1:0]   l_cnt  = (l_last >> 3) + WC_W'(1);
  wire [ADDR_W-1:0] l_sptr = (sline - ADDR_W'(dline[2:0])) & WORD_MASK;

  wire [7:0] m_left  = 8'hFF << doff;
  wire [7:0] m_right = 8'hFF >> (3'd7 - eoff);

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign mem_req   = (st == S_PRIME) || (st == S_RD) || (st == S_WR);
  assign mem_we    = (st == S_WR);
  assign mem_addr  = mem_we ? dptr : sptr;
  assign mem_be    = (first ? m_left : 8'hFF) & ((wleft == WC_W'(1)) ? m_right : 8'hFF);
  assign mem_wdata = (sh == 3'd0) ? cur : 64'({cur, prev} >> {sh, 3'b000});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      sline <= '0; dline <= '0; sstr <= '0; dstr <= '0;
      sptr <= '0; dptr <= '0; wbytes <= '0; lines <= '0;
      wleft <= '0; first <= 1'b0; done_q <= 1'b0;
      doff <= '0; eoff <= '0; sh <= '0; cur <= '0; prev <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (empty) done_q <= 1'b1;
          else begin
            sline  <= src_addr & a_round;
            dline  <= dst_addr & a_round;
            sstr   <= src_stride;
            dstr   <= dst_stride;
            wbytes <= w_in;
            lines  <= height;
            st     <= S_LINE;
          end
        end
        S_LINE: begin
          dptr  <= dline & WORD_MASK;
          sptr  <= l_sptr;
          wleft <= l_cnt;
          first <= 1'b1;
          doff  <= dline[2:0];
          eoff  <= l_last[2:0];
          sh    <= sline[2:0] - dline[2:0];
          st    <= (sline[2:0] != dline[2:0]) ? S_PRIME : S_RD;
        end
        S_PRIME: if (mem_ready) begin
          cur  <= mem_rdata;
          sptr <= sptr + ADDR_W'(8);
          st   <= S_RD;
        end
        S_RD: if (mem_ready) begin
          prev <= cur;
          cur  <= mem_rdata;
          sptr <= sptr + ADDR_W'(8);
          st   <= S_WR;
        end
        S_WR: if (mem_ready) begin
          dptr  <= dptr + ADDR_W'(8);
          first <= 1'b0;
          wleft <= wleft - WC_W'(1);
          if (wleft == WC_W'(1)) begin
            if (lines == DIM_W'(1)) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end else begin
              lines <= lines - DIM_W'(1);
              sline <= sline + sstr;
              dline <= dline + dstr;
              st    <= S_LINE;
            end
          end else st <= S_RD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r2_done_pulse: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  a_r2_done_idle: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  a_r3_aligned: assert property (@(posedge clk) disable iff (!rst_n) mem_req |-> mem_addr[2:0] == 3'b000);
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we));
  a_r4_be_nonzero: assert property (@(posedge clk) disable iff (!rst_n) mem_req && mem_we |-> mem_be != 8'h00);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !mem_req);
  a_r9_cfg_held: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(wbytes) && $stable(sstr) && $stable(dstr));
endmodule

// File: tb/rect_blit_tb.sv
module rect_blit_tb;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, pix32 = 1'b0;
  logic [31:0] src_addr = '0, dst_addr = '0, src_stride = '0, dst_stride = '0;
  logic [15:0] width = '0, height = '0;
  logic busy, done, mem_req, mem_we, mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [7:0]  mem_be;
  logic [63:0] mem_wdata, mem_rdata;

  always #10 clk = ~clk;

  rect_blit u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix32(pix32),
    .src_addr(src_addr), .dst_addr(dst_addr), .src_stride(src_stride), .dst_stride(dst_stride),
    .width(width), .height(height), .busy(busy), .done(done),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready));

  logic [7:0] mem [0:4095];
  logic [7:0] img0 [0:4095];
  logic [7:0] want [0:4095];
  logic [31:0] qa[$];
  logic [7:0]  qb[$];
  logic [63:0] qd[$];
  int checks = 0, errors = 0, cyc = 0, rmode = 0, reqs = 0, dones = 0;
  bit prev_done = 1'b0, finished = 1'b0;

  always_comb
    for (int j = 0; j < 8; j++) mem_rdata[8*j +: 8] = mem[{mem_addr[11:3], 3'(j)}];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      chk(1'b0, "watchdog", cyc, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    case (rmode)
      1: mem_ready = (cyc % 3) != 0;
      2: mem_ready = (cyc % 5) < 2;
      default: mem_ready = 1'b1;
    endcase
    if (mem_req && mem_ready) begin
      reqs++;
      if (mem_we) begin
        if (qa.size() == 0) chk(1'b0, "R10 extra write", mem_addr, 0);
        else begin
          logic [31:0] ea; logic [7:0] eb; logic [63:0] ed;
          ea = qa.pop_front(); eb = qb.pop_front(); ed = qd.pop_front();
          chk(mem_addr == ea, "R6 R10 write address", mem_addr, ea);
          chk(mem_be == eb, "R4 byte enables", mem_be, eb);
          for (int j = 0; j < 8; j++)
            if (eb[j] && mem_wdata[8*j +: 8] != ed[8*j +: 8])
              chk(1'b0, "R5 write byte", mem_wdata[8*j +: 8], ed[8*j +: 8]);
        end
        for (int j = 0; j < 8; j++)
          if (mem_be[j]) mem[{mem_addr[11:3], 3'(j)}] = mem_wdata[8*j +: 8];
      end
    end
    if (done) begin
      dones++;
      if (prev_done) chk(1'b0, "R2 done longer than one cycle", 1, 0);
    end
    prev_done = done;
  end

  task automatic run_job(input int s, input int d, input int ss, input int ds, input int w,
                         input int h, input bit p32, input int rm, input bit disturb);
    int rs, rd, rw, base_dones, t;
    int m;
    m = p32 ? 3 : 1;
    rs = s & ~m; rd = d & ~m; rw = w & ~m;
    for (int i = 0; i < 4096; i++) begin
      img0[i] = 8'(i * 37 + (i >> 5) + 11);
      mem[i] = img0[i];
      want[i] = img0[i];
    end
    qa.delete(); qb.delete(); qd.delete();
    if (rw > 0)
      for (int y = 0; y < h; y++) begin
        int dl, sl;
        dl = rd + y * ds; sl = rs + y * ss;
        for (int x = 0; x < rw; x++) want[dl + x] = img0[sl + x];
        for (int a = dl & ~7; a <= ((dl + rw - 1) & ~7); a += 8) begin
          logic [7:0] be; logic [63:0] dat;
          be = '0; dat = '0;
          for (int j = 0; j < 8; j++)
            if (a + j >= dl && a + j < dl + rw) begin
              be[j] = 1'b1;
              dat[8*j +: 8] = img0[sl + a + j - dl];
            end
          qa.push_back(32'(a)); qb.push_back(be); qd.push_back(dat);
        end
      end
    @(negedge clk);
    rmode = rm;
    src_addr = 32'(s); dst_addr = 32'(d); src_stride = 32'(ss); dst_stride = 32'(ds);
    width = 16'(w); height = 16'(h); pix32 = p32;
    reqs = 0; base_dones = dones;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (rw == 0 || h == 0) begin
      chk(done == 1'b1, "R8 done one cycle after start", done, 1);
      chk(busy == 1'b0, "R8 busy stays low", busy, 0);
    end else begin
      chk(busy == 1'b1, "R2 busy after start", busy, 1);
      if (disturb) begin
        repeat (4) @(negedge clk);
        dst_addr = 32'd3000; width = 16'd8; src_stride = 32'd16; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    end
    t = 0;
    while (dones == base_dones && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(dones == base_dones + 1, "R2 done seen", dones - base_dones, 1);
    chk(busy == 1'b0, "R2 busy low with done", busy, 0);
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
    chk(qa.size() == 0, "R10 write count", qa.size(), 0);
    if (rw == 0 || h == 0) chk(reqs == 0, "R8 no memory access", reqs, 0);
    begin
      int bad;
      bad = -1;
      for (int i = 0; i < 4096; i++) if (bad < 0 && mem[i] != want[i]) bad = i;
      if (bad >= 0) chk(1'b0, "R4 R5 R7 R9 memory image", bad, want[bad]);
      else chk(1'b1, "R4 R5 memory image", 0, 0);
    end
    rmode = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && mem_req == 1'b0, "R1 reset outputs", {busy, done, mem_req}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && mem_req == 1'b0, "R1 idle after reset", {busy, mem_req}, 0);
    run_job(64, 2048, 256, 320, 32, 3, 1'b0, 0, 1'b0);   // R2 R6 aligned
    run_job(101, 2051, 200, 168, 37, 4, 1'b0, 1, 1'b0);  // R5 R7 offsets
    run_job(10, 2061, 40, 24, 3, 2, 1'b0, 0, 1'b0);      // R10 single-word line
    run_job(7, 2311, 96, 120, 23, 5, 1'b1, 2, 1'b0);     // R7 32-bit pixels
    run_job(16, 2100, 8, 8, 3, 4, 1'b1, 0, 1'b0);        // R8 width rounds to zero
    run_job(16, 2100, 8, 8, 16, 0, 1'b0, 0, 1'b0);       // R8 zero height
    run_job(33, 2093, 180, 300, 61, 3, 1'b0, 1, 1'b1);   // R9 start while busy
    run_job(1000, 2054, 64, 72, 40, 3, 1'b0, 2, 1'b0);   // R5 source offset below destination
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule